// File: doc/BRIEF.md
# Byte-Fetched Stack Machine Core

This block is a small multicycle processor with no general-purpose registers. All arithmetic operands sit in a private stack RAM, addressed by a stack-pointer register that grows toward higher addresses. The stack pointer names the current top entry. An all-ones value means the stack is empty. Program code and data share one external byte-wide memory. Each cycle the core makes at most one access to that memory, either a read or a write.

A control state machine steps through each instruction. It first reads the opcode byte. For the three long forms it then reads the address bytes one at a time, most significant byte first. After that it carries out the stack and memory accesses the instruction needs. Instructions sit back to back in memory: a one-byte add, and three-byte push, pop and branch-if-equal. An unknown opcode stops the core until the next reset.

The external memory is synchronous. The core drives an address with a read strobe in one cycle, and the memory must return the byte on `mem_rdata` in the next cycle. Writes take effect at the clock edge that ends the cycle in which `mem_wr` is high. The memory port has no back-pressure: it must accept an access in every cycle, because the core never waits.

Top module: `stack_cpu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the core reads the opcode at address 0. `mem_wr` and `halted` are low, and the stack is empty (stack pointer all ones).
- R2: Opcodes are 0x00 push, 0x01 pop, 0x02 add and 0x04 branch-if-equal. Add is one byte long. The other three are followed by a two-byte address, high byte first, read from consecutive addresses. The next instruction starts at the byte after the current one.
- R3: Push reads the memory byte at the instruction's address and places it on the stack as the new top.
- R4: Pop writes the top of the stack to the instruction's address and removes that entry, so values come back in last-in, first-out order.
- R5: Add removes the two top entries and pushes their sum modulo 256.
- R6: Branch-if-equal removes the two top entries. If they are equal, the next opcode is read from the instruction's address.
- R7: If the two entries differ, branch-if-equal still removes both, and execution continues with the next sequential instruction.
- R8: An opcode outside the four defined values raises `halted`, which stays high. The core then makes no further memory reads or writes until reset.
- R9: The core never reads and writes memory in the same cycle. Push and pop take 7 cycles, add takes 5 and branch-if-equal takes 8. A pop's write therefore appears in the last cycle of that pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Byte address for the program/data memory |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after mem_rd |
| halted | output | 1 | High after an undefined opcode has been decoded |

## Verification
The bench uses the default parameters: 16-bit memory addresses, 8-bit data, and a 256-entry stack. These values put the two-byte address field within reach, so a byte-order fault sends accesses to a distant address. Sums above 255 exercise the wrap of the adder. The empty-stack encoding is tested by a push into entry 0 straight after reset. Branch targets are placed away from the fall-through path, so a wrong branch decision or a wrong stack depth shows up as a wrong or unexpected write.

// File: rtl/stack_cpu_pkg.sv
package stack_cpu_pkg;

  localparam logic [7:0] OPC_PUSH = 8'h00;
  localparam logic [7:0] OPC_POP  = 8'h01;
  localparam logic [7:0] OPC_ADD  = 8'h02;
  localparam logic [7:0] OPC_BEQ  = 8'h04;

  typedef enum logic [1:0] {
    K_PUSH,
    K_POP,
    K_ADD,
    K_BEQ
  } kind_e;

  typedef enum logic [3:0] {
    S_FETCH,
    S_DECODE,
    S_ABYTE,
    S_ALAST,
    S_PUSH_RD,
    S_PUSH_WR,
    S_POP_RD,
    S_POP_WR,
    S_PAIR_RD1,
    S_PAIR_RD2,
    S_ADD_WR,
    S_BEQ_RES,
    S_HALT
  } state_e;

endpackage

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int SP_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SP_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SP_W-1:0]   raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << SP_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // synchronous read, one cycle latency; write lands at the same edge
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/stack_alu.sv
module stack_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              eq
);
  // sum wraps at the data width
  assign sum = a + b;
  assign eq  = (a == b);
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_cpu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic              stk_we,
  output logic [SP_W-1:0]   stk_waddr,
  output logic [DATA_W-1:0] stk_wdata,
  output logic [SP_W-1:0]   stk_raddr,
  input  logic [DATA_W-1:0] stk_rdata,
  output logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] alu_sum,
  input  logic              alu_eq
);
  localparam int ADDR_BYTES = ADDR_W / DATA_W;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(ADDR_BYTES - 1);
  localparam logic [ADDR_W-1:0] PC_ONE   = ADDR_W'(1);
  localparam logic [SP_W-1:0]   SP_ONE   = SP_W'(1);
  localparam logic [SP_W-1:0]   SP_TWO   = SP_W'(2);

  state_e            state, nxt;
  kind_e             kind, dec_kind;
  logic              dec_ok;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] oper;
  logic [ADDR_W-1:0] oper_shift;
  logic [SP_W-1:0]   sp;
  logic [CNT_W-1:0]  cnt;

  // opcode decoder
  always_comb begin
    dec_ok   = 1'b1;
    dec_kind = K_ADD;
    if      (mem_rdata == DATA_W'(OPC_PUSH)) dec_kind = K_PUSH;
    else if (mem_rdata == DATA_W'(OPC_POP))  dec_kind = K_POP;
    else if (mem_rdata == DATA_W'(OPC_ADD))  dec_kind = K_ADD;
    else if (mem_rdata == DATA_W'(OPC_BEQ))  dec_kind = K_BEQ;
    else                                     dec_ok   = 1'b0;
  end

  // address bytes arrive high first: shift left, append the new byte
  assign oper_shift = {oper[ADDR_W-DATA_W-1:0], mem_rdata};

  // next-state logic
  always_comb begin
    nxt = state;
    unique case (state)
      S_FETCH:    nxt = S_DECODE;
      S_DECODE: begin
        if (!dec_ok)               nxt = S_HALT;
        else if (dec_kind == K_ADD) nxt = S_PAIR_RD1;
        else                       nxt = S_ABYTE;
      end
      S_ABYTE:    nxt = (cnt == LAST_CNT) ? S_ALAST : S_ABYTE;
      S_ALAST: begin
        unique case (kind)
          K_PUSH:  nxt = S_PUSH_RD;
          K_POP:   nxt = S_POP_RD;
          default: nxt = S_PAIR_RD1;
        endcase
      end
      S_PUSH_RD:  nxt = S_PUSH_WR;
      S_PUSH_WR:  nxt = S_FETCH;
      S_POP_RD:   nxt = S_POP_WR;
      S_POP_WR:   nxt = S_FETCH;
      S_PAIR_RD1: nxt = S_PAIR_RD2;
      S_PAIR_RD2: nxt = (kind == K_ADD) ? S_ADD_WR : S_BEQ_RES;
      S_ADD_WR:   nxt = S_FETCH;
      S_BEQ_RES:  nxt = S_FETCH;
      S_HALT:     nxt = S_HALT;
      default:    nxt = S_HALT;
    endcase
  end

  // datapath registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      kind  <= K_ADD;
      pc    <= '0;
      oper  <= '0;
      sp    <= '1;
      cnt   <= '0;
      opa   <= '0;
    end else begin
      state <= nxt;
      unique case (state)
        S_FETCH:  pc <= pc + PC_ONE;
        S_DECODE: begin
          kind <= dec_kind;
          cnt  <= '0;
        end
        S_ABYTE: begin
          pc  <= pc + PC_ONE;
          cnt <= cnt + CNT_W'(1);
          if (cnt != '0) oper <= oper_shift;
        end
        S_ALAST:    oper <= oper_shift;
        S_PUSH_WR:  sp <= sp + SP_ONE;
        S_POP_WR:   sp <= sp - SP_ONE;
        S_PAIR_RD2: opa <= stk_rdata;
        S_ADD_WR:   sp <= sp - SP_ONE;
        S_BEQ_RES: begin
          sp <= sp - SP_TWO;
          if (alu_eq) pc <= oper;
        end
        default: ;
      endcase
    end
  end

  // port and stack-RAM controls
  always_comb begin
    mem_rd    = (state == S_FETCH) || (state == S_ABYTE) || (state == S_PUSH_RD);
    mem_wr    = (state == S_POP_WR);
    mem_addr  = ((state == S_PUSH_RD) || (state == S_POP_WR)) ? oper : pc;
    mem_wdata = stk_rdata;
    stk_raddr = (state == S_PAIR_RD2) ? (sp - SP_ONE) : sp;
    stk_we    = (state == S_PUSH_WR) || (state == S_ADD_WR);
    stk_waddr = (state == S_PUSH_WR) ? (sp + SP_ONE) : (sp - SP_ONE);
    stk_wdata = (state == S_PUSH_WR) ? mem_rdata : alu_sum;
    halted    = (state == S_HALT);
  end

  // R9: one memory port, never read and write together
  p_single_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R8: halt is sticky
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R8: undefined opcode leads to halt
  p_bad_opcode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE && !dec_ok) |=> halted);

  // R2: address bytes come from consecutive locations
  p_addr_bytes_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ABYTE && $past(state) == S_ABYTE) |-> mem_addr == $past(mem_addr) + PC_ONE);

  // R4: pop removes exactly one entry
  p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POP_WR) |=> sp == $past(sp) - SP_ONE);

  // R6: compare removes two entries
  p_beq_pops_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BEQ_RES) |=> sp == $past(sp) - SP_TWO);

endmodule

// File: rtl/stack_cpu.sv
module stack_cpu #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  logic              stk_we;
  logic [SP_W-1:0]   stk_waddr;
  logic [DATA_W-1:0] stk_wdata;
  logic [SP_W-1:0]   stk_raddr;
  logic [DATA_W-1:0] stk_rdata;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] alu_sum;
  logic              alu_eq;

  stack_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .stk_we    (stk_we),
    .stk_waddr (stk_waddr),
    .stk_wdata (stk_wdata),
    .stk_raddr (stk_raddr),
    .stk_rdata (stk_rdata),
    .opa       (opa),
    .alu_sum   (alu_sum),
    .alu_eq    (alu_eq)
  );

  stack_ram #(.SP_W(SP_W), .DATA_W(DATA_W)) u_stack (
    .clk   (clk),
    .we    (stk_we),
    .waddr (stk_waddr),
    .wdata (stk_wdata),
    .raddr (stk_raddr),
    .rdata (stk_rdata)
  );

  stack_alu #(.DATA_W(DATA_W)) u_alu (
    .a   (opa),
    .b   (stk_rdata),
    .sum (alu_sum),
    .eq  (alu_eq)
  );
endmodule

// File: tb/test_stack_cpu.sv
module test_stack_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  typedef struct {
    int    addr;
    int    data;
    int    at;
    string req;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] mem [int];

  always #4 clk = ~clk;

  stack_cpu i_stack_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted)
  );

  // synchronous byte memory model
  always @(posedge clk) begin
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  task automatic put(input int a, input int v);
    mem[a] = v[7:0];
  endtask

  task automatic expect_wr(input int a, input int d, input int at, input string req);
    exp_t e;
    e.addr = a; e.data = d; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: compares every memory write with the queue head
  always @(negedge clk) begin
    if (!rst_n) cyc = 0;
    else begin
      if (mem_wr) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 R7 unexpected write", int'(mem_addr), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(mem_addr) == e.addr, {e.req, " addr"}, int'(mem_addr), e.addr);
          check(int'(mem_wdata) == e.data, {e.req, " data"}, int'(mem_wdata), e.data);
          if (e.at >= 0) check(cyc == e.at, "R9 write cycle", cyc, e.at);
        end
      end
      cyc++;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_until_halt(input int limit);
    for (int i = 0; i < limit && !halted; i++) @(negedge clk);
    check(halted, "R8 reached halt (watchdog)", int'(halted), 1);
    check(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // ---- program A: push, push, add (wraps), pop, halt
    mem.delete();
    put(0, 8'h00); put(1, 8'h01); put(2, 8'h00);
    put(3, 8'h00); put(4, 8'h01); put(5, 8'h01);
    put(6, 8'h02);
    put(7, 8'h01); put(8, 8'h02); put(9, 8'h00);
    put(10, 8'h08);
    put(16'h0100, 8'h5A); put(16'h0101, 8'hC3);
    // R3 R5 R2: 0x5A+0xC3 wraps to 0x1D; pop write is cycle 25 (7+7+5+7-1) for R9
    expect_wr(16'h0200, 8'h1D, 25, "R2 R3 R5");
    @(negedge clk);
    do_reset();
    #1;
    // R1: first cycle after reset reads address 0
    check(mem_rd == 1'b1, "R1 read strobe", int'(mem_rd), 1);
    check(mem_addr == 16'h0000, "R1 fetch address", int'(mem_addr), 0);
    check(mem_wr == 1'b0, "R1 no write", int'(mem_wr), 0);
    check(halted == 1'b0, "R1 not halted", int'(halted), 0);
    run_until_halt(200);

    // ---- program B: last-in first-out pops, stack reused after emptying
    mem.delete();
    put(0, 8'h00); put(1, 8'h01); put(2, 8'h10);
    put(3, 8'h00); put(4, 8'h01); put(5, 8'h11);
    put(6, 8'h01); put(7, 8'h03); put(8, 8'h00);
    put(9, 8'h01); put(10, 8'h03); put(11, 8'h01);
    put(12, 8'h00); put(13, 8'h01); put(14, 8'h12);
    put(15, 8'h01); put(16, 8'h03); put(17, 8'h02);
    put(18, 8'hFF);
    put(16'h0110, 8'h11); put(16'h0111, 8'h22); put(16'h0112, 8'h33);
    expect_wr(16'h0300, 8'h22, -1, "R4 first pop");
    expect_wr(16'h0301, 8'h11, -1, "R4 second pop");
    expect_wr(16'h0302, 8'h33, -1, "R3 R4 after empty");
    do_reset();
    run_until_halt(300);

    // ---- program C: equal compare branches, both entries removed
    mem.delete();
    put(0, 8'h00); put(1, 8'h01); put(2, 8'h20);
    put(3, 8'h00); put(4, 8'h01); put(5, 8'h21);
    put(6, 8'h00); put(7, 8'h01); put(8, 8'h22);
    put(9, 8'h04); put(10, 8'h00); put(11, 8'h40);
    put(12, 8'h01); put(13, 8'h04); put(14, 8'h00);
    put(15, 8'hFF);
    put(16'h0040, 8'h01); put(16'h0041, 8'h04); put(16'h0042, 8'h02);
    put(16'h0043, 8'hFF);
    put(16'h0120, 8'h44); put(16'h0121, 8'h77); put(16'h0122, 8'h77);
    expect_wr(16'h0402, 8'h44, -1, "R6 taken branch");
    do_reset();
    run_until_halt(300);

    // ---- program D: unequal compare falls through, both entries removed
    mem.delete();
    put(0, 8'h00); put(1, 8'h01); put(2, 8'h30);
    put(3, 8'h00); put(4, 8'h01); put(5, 8'h31);
    put(6, 8'h00); put(7, 8'h01); put(8, 8'h32);
    put(9, 8'h04); put(10, 8'h00); put(11, 8'h50);
    put(12, 8'h01); put(13, 8'h05); put(14, 8'h00);
    put(15, 8'hFF);
    put(16'h0050, 8'h01); put(16'h0051, 8'h05); put(16'h0052, 8'h01);
    put(16'h0053, 8'hFF);
    put(16'h0130, 8'h55); put(16'h0131, 8'h03); put(16'h0132, 8'h04);
    expect_wr(16'h0500, 8'h55, -1, "R7 fall through");
    do_reset();
    run_until_halt(300);

    // ---- program E: undefined opcode first
    mem.delete();
    put(0, 8'h03); put(1, 8'h01); put(2, 8'h00); put(3, 8'h00);
    do_reset();
    run_until_halt(50);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!mem_rd && !mem_wr, "R8 quiet after halt", int'({mem_rd, mem_wr}), 0);
      check(halted, "R8 halt held", int'(halted), 1);
    end

    summary();
    $finish;
  end
endmodule